// File: doc/BRIEF.md
# Coprocessor Special Register File

This block is the register file and address decoder for a small 24-bit signal-processing coprocessor. A 7-bit register address selects one of several kinds of location: a 48-bit multiplier result seen as two 24-bit halves, a set of named working registers (memory data, memory address, ROM, RAM, data pointer, program counter, page), sixteen general-purpose registers that answer at two address aliases, and a bank of sixteen fixed constants that software reads as immediate operands.

Two addresses do not hold data. Any access to them starts a transfer on the external memory bus, toward ROM at one address and toward RAM at the other. The transfer takes its direction from the kind of access and its address from the memory address register. The block loads a wait-state countdown, holds the bus-busy output high while the countdown is nonzero, and lowers it on its own once the count reaches zero.

The register port is a plain strobe interface with no back-pressure: it accepts every access in the cycle it is presented. Read data is combinational from the address. Writes and transfer starts take effect at the next rising clock edge. The instruction decoder, the ALU and the memory models sit outside this block.

Top module: `sproc_regfile`

## Requirements
- R1: On a synchronous active-high reset, all storage clears to zero. Every non-constant address then reads 0x000000, and `bus_busy`, `bus_rd` and `bus_wr` are low.
- R2: The multiplier result is 48 bits. Address 0x01 reads and writes bits 47..24, and address 0x02 reads and writes bits 23..0. A write to one half leaves the other half unchanged.
- R3: The memory data register (0x03), ROM register (0x08), RAM register (0x0C), memory address register (0x13), data pointer (0x1C), program counter (0x20) and page register (0x28) each return the last value written to them.
- R4: Addresses 0x50..0x5F return the constants 000000, FFFFFF, 00FF00, FF0000, 00FFFF, FFFF00, 800000, 7FFFFF, 008000, 007FFF, FF7FFF, FFFF7F, 010000, FEFFFF, 000100, 00FEFF (hex), indexed by address bits 3..0. Writes to these addresses have no effect.
- R5: General-purpose register n (n = address bits 3..0) answers at both 0x60+n and 0x70+n. A write through either alias is seen through both.
- R6: An access to 0x2E starts a ROM transfer (`bus_ram`=0), and an access to 0x2F starts a RAM transfer (`bus_ram`=1). A write strobe gives a write transfer (`bus_wr`), and a read strobe alone gives a read transfer (`bus_rd`). If both strobes are set, the write strobe decides the direction. `bus_addr` takes the memory address register value held before that edge.
- R7: A started transfer loads a countdown of 1 + `rom_wait` (0x2E) or 1 + `ram_wait` (0x2F). The countdown falls by one each clock, so `bus_busy` stays high for exactly 1 + wait cycles after the starting edge. `bus_rd` and `bus_wr` are never high together, and both are low when the bus is idle.
- R8: Reads of 0x2E, 0x2F and every unmapped address return 0x000000.
- R9: A new transfer started while one is still busy replaces it: the countdown, direction, target and address all reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 7 | Register address |
| reg_rd | input | 1 | Read strobe (matters only for transfer start) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 24 | Write data |
| reg_rdata | output | 24 | Combinational read data for `reg_addr` |
| rom_wait | input | 3 | ROM wait states |
| ram_wait | input | 3 | RAM wait states |
| bus_busy | output | 1 | Transfer countdown nonzero |
| bus_rd | output | 1 | Busy with a read transfer |
| bus_wr | output | 1 | Busy with a write transfer |
| bus_ram | output | 1 | Current transfer targets RAM (0 = ROM) |
| bus_addr | output | 24 | Transfer address |

## Verification
Read data is due in the same cycle as the address, so the bench drives the address on a falling edge and samples a moment later, before the next rising edge. A write shows up in read data after the following rising edge, and the bench reads it back one falling edge later. A transfer raises `bus_busy` at the edge that samples the strobe. The bench therefore samples the bus outputs at each falling edge after that edge and expects exactly 1 + wait high samples, and it checks the direction, target and address on the first of them. The retrigger case starts a second transfer while the first is busy and expects the busy count to follow the second transfer's wait value.

// File: rtl/sproc_pkg.sv
package sproc_pkg;
  localparam int DATA_W  = 24;
  localparam int ADDR_W  = 7;
  localparam int WAIT_W  = 3;
  localparam int NUM_GPR = 16;

  localparam logic [ADDR_W-1:0] A_MUL_HI = 7'h01;
  localparam logic [ADDR_W-1:0] A_MUL_LO = 7'h02;
  localparam logic [ADDR_W-1:0] A_MDR    = 7'h03;
  localparam logic [ADDR_W-1:0] A_ROMR   = 7'h08;
  localparam logic [ADDR_W-1:0] A_RAMR   = 7'h0C;
  localparam logic [ADDR_W-1:0] A_MAR    = 7'h13;
  localparam logic [ADDR_W-1:0] A_DPTR   = 7'h1C;
  localparam logic [ADDR_W-1:0] A_PC     = 7'h20;
  localparam logic [ADDR_W-1:0] A_PAGE   = 7'h28;
  localparam logic [ADDR_W-1:0] A_XROM   = 7'h2E;
  localparam logic [ADDR_W-1:0] A_XRAM   = 7'h2F;

  typedef logic [DATA_W-1:0] word_t;

  // Fixed operand table, indexed by the low nibble of the address.
  function automatic word_t const_value(input logic [3:0] idx);
    word_t v;
    case (idx)
      4'h0: v = 24'h000000;
      4'h1: v = 24'hFFFFFF;
      4'h2: v = 24'h00FF00;
      4'h3: v = 24'hFF0000;
      4'h4: v = 24'h00FFFF;
      4'h5: v = 24'hFFFF00;
      4'h6: v = 24'h800000;
      4'h7: v = 24'h7FFFFF;
      4'h8: v = 24'h008000;
      4'h9: v = 24'h007FFF;
      4'hA: v = 24'hFF7FFF;
      4'hB: v = 24'hFFFF7F;
      4'hC: v = 24'h010000;
      4'hD: v = 24'hFEFFFF;
      4'hE: v = 24'h000100;
      default: v = 24'h00FEFF;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/sproc_named_regs.sv
module sproc_named_regs
  import sproc_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          hit,
  output logic [DW-1:0] mar
);
  localparam int MW = 2 * DW;

  logic [MW-1:0] mul_q;
  logic [DW-1:0] mdr_q, romr_q, ramr_q, mar_q, dptr_q, pc_q, page_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mul_q  <= '0;
      mdr_q  <= '0;
      romr_q <= '0;
      ramr_q <= '0;
      mar_q  <= '0;
      dptr_q <= '0;
      pc_q   <= '0;
      page_q <= '0;
    end else if (wr_en) begin
      case (addr)
        A_MUL_HI: mul_q[MW-1:DW] <= wdata;
        A_MUL_LO: mul_q[DW-1:0]  <= wdata;
        A_MDR:    mdr_q  <= wdata;
        A_ROMR:   romr_q <= wdata;
        A_RAMR:   ramr_q <= wdata;
        A_MAR:    mar_q  <= wdata;
        A_DPTR:   dptr_q <= wdata;
        A_PC:     pc_q   <= wdata;
        A_PAGE:   page_q <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    hit   = 1'b1;
    rdata = '0;
    case (addr)
      A_MUL_HI: rdata = mul_q[MW-1:DW];
      A_MUL_LO: rdata = mul_q[DW-1:0];
      A_MDR:    rdata = mdr_q;
      A_ROMR:   rdata = romr_q;
      A_RAMR:   rdata = ramr_q;
      A_MAR:    rdata = mar_q;
      A_DPTR:   rdata = dptr_q;
      A_PC:     rdata = pc_q;
      A_PAGE:   rdata = page_q;
      default:  hit = 1'b0;
    endcase
  end

  assign mar = mar_q;

  // R2: writing one half leaves the other half untouched
  assert_mul_lo_kept_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_MUL_HI) |=> mul_q[DW-1:0] == $past(mul_q[DW-1:0]));
  assert_mul_hi_kept_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_MUL_LO) |=> mul_q[MW-1:DW] == $past(mul_q[MW-1:DW]));
  // R3: a write to the address register lands there
  assert_mar_written_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_MAR) |=> mar_q == $past(wdata));
endmodule

// File: rtl/sproc_gpr_bank.sv
module sproc_gpr_bank
  import sproc_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int N  = NUM_GPR
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          hit
);
  localparam int IW = $clog2(N);

  logic [DW-1:0] regs_q [N];
  logic [IW-1:0] idx;

  // Both the 0x6x and the 0x7x windows decode here; bit 4 is ignored.
  assign hit = (addr[AW-1:AW-2] == 2'b11);
  assign idx = addr[IW-1:0];

  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs_q[i] <= '0;
      else if (wr_en && hit && idx == IW'(i))
        regs_q[i] <= wdata;
    end
  end

  assign rdata = regs_q[idx];

  // R5: a write through either alias lands in the shared register
  assert_gpr_alias_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hit) |=> regs_q[$past(idx)] == $past(wdata));
endmodule

// File: rtl/sproc_const_rom.sv
module sproc_const_rom
  import sproc_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] rdata,
  output logic          hit
);
  assign hit   = (addr[AW-1:4] == 3'b101);
  assign rdata = DW'(const_value(addr[3:0]));
endmodule

// File: rtl/sproc_xfer_ctrl.sv
module sproc_xfer_ctrl
  import sproc_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int WW = WAIT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          start_wr,
  input  logic          start_ram,
  input  logic [DW-1:0] start_addr,
  input  logic [WW-1:0] rom_wait,
  input  logic [WW-1:0] ram_wait,
  output logic          busy,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic          bus_ram,
  output logic [DW-1:0] bus_addr
);
  localparam int CW = WW + 1;

  logic [CW-1:0] cnt_q;
  logic          wr_q, ram_q;
  logic [DW-1:0] addr_q;
  logic [WW-1:0] wait_sel;

  assign wait_sel = start_ram ? ram_wait : rom_wait;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      wr_q   <= 1'b0;
      ram_q  <= 1'b0;
      addr_q <= '0;
    end else if (start) begin
      cnt_q  <= CW'(wait_sel) + CW'(1);
      wr_q   <= start_wr;
      ram_q  <= start_ram;
      addr_q <= start_addr;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign busy     = (cnt_q != '0);
  assign bus_rd   = busy & ~wr_q;
  assign bus_wr   = busy & wr_q;
  assign bus_ram  = ram_q;
  assign bus_addr = addr_q;

  // R7: countdown loads one plus the selected wait value
  assert_cnt_load_R7: assert property (@(posedge clk) disable iff (rst)
    start |=> cnt_q == CW'($past(start_ram ? ram_wait : rom_wait)) + CW'(1));
  // R7: countdown falls by exactly one per idle clock
  assert_cnt_step_R7: assert property (@(posedge clk) disable iff (rst)
    (!start && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CW'(1));
  // R7: direction flags are exclusive
  assert_dir_excl_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({bus_rd, bus_wr}));
  // R6: transfer address is captured at the start edge
  assert_addr_capture_R6: assert property (@(posedge clk) disable iff (rst)
    start |=> bus_addr == $past(start_addr));
endmodule

// File: rtl/sproc_regfile.sv
module sproc_regfile
  import sproc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_rd,
  input  logic               reg_wr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [WAIT_W-1:0]  rom_wait,
  input  logic [WAIT_W-1:0]  ram_wait,
  output logic               bus_busy,
  output logic               bus_rd,
  output logic               bus_wr,
  output logic               bus_ram,
  output logic [DATA_W-1:0]  bus_addr
);
  logic [DATA_W-1:0] named_rd, gpr_rd, const_rd, mar;
  logic              named_hit, gpr_hit, const_hit;
  logic              xfer_addr, xfer_start;

  sproc_named_regs #(.DW(DATA_W), .AW(ADDR_W)) u_named (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(named_rd), .hit(named_hit), .mar(mar)
  );

  sproc_gpr_bank #(.DW(DATA_W), .AW(ADDR_W), .N(NUM_GPR)) u_gpr (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(gpr_rd), .hit(gpr_hit)
  );

  sproc_const_rom #(.DW(DATA_W), .AW(ADDR_W)) u_const (
    .addr(reg_addr), .rdata(const_rd), .hit(const_hit)
  );

  assign xfer_addr  = (reg_addr == A_XROM) || (reg_addr == A_XRAM);
  assign xfer_start = xfer_addr && (reg_rd || reg_wr);

  sproc_xfer_ctrl #(.DW(DATA_W), .WW(WAIT_W)) u_xfer (
    .clk(clk), .rst(rst), .start(xfer_start), .start_wr(reg_wr),
    .start_ram(reg_addr == A_XRAM), .start_addr(mar),
    .rom_wait(rom_wait), .ram_wait(ram_wait),
    .busy(bus_busy), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_ram(bus_ram), .bus_addr(bus_addr)
  );

  always_comb begin
    if (gpr_hit)        reg_rdata = gpr_rd;
    else if (const_hit) reg_rdata = const_rd;
    else if (named_hit) reg_rdata = named_rd;
    else                reg_rdata = '0;
  end

  // R8: transfer-start addresses read as zero
  always_comb begin
    if (!rst && xfer_addr)
      assert_xfer_read_zero_R8: assert (reg_rdata == '0);
  end

  // R1: bus is idle in the cycle after reset
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> !bus_busy && !bus_rd && !bus_wr);
endmodule

// File: tb/sproc_regfile_bench.sv
module sproc_regfile_bench;
  import sproc_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  reg_addr = '0;
  logic        reg_rd = 1'b0, reg_wr = 1'b0;
  logic [23:0] reg_wdata = '0;
  logic [23:0] reg_rdata;
  logic [2:0]  rom_wait = '0, ram_wait = '0;
  logic        bus_busy, bus_rd, bus_wr, bus_ram;
  logic [23:0] bus_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  sproc_regfile u_sproc_regfile (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rom_wait(rom_wait),
    .ram_wait(ram_wait), .bus_busy(bus_busy), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_ram(bus_ram), .bus_addr(bus_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] pat(input int a);
    return {8'(a), 8'(a ^ 8'h3C), 8'(~a)};
  endfunction

  function automatic logic [23:0] cval(input int i);
    case (i)
      0: return 24'h000000;  1: return 24'hFFFFFF;  2: return 24'h00FF00;
      3: return 24'hFF0000;  4: return 24'h00FFFF;  5: return 24'hFFFF00;
      6: return 24'h800000;  7: return 24'h7FFFFF;  8: return 24'h008000;
      9: return 24'h007FFF; 10: return 24'hFF7FFF; 11: return 24'hFFFF7F;
     12: return 24'h010000; 13: return 24'hFEFFFF; 14: return 24'h000100;
      default: return 24'h00FEFF;
    endcase
  endfunction

  function automatic bit is_named(input int a);
    return a == 1 || a == 2 || a == 3 || a == 8 || a == 12 || a == 'h13 ||
           a == 'h1C || a == 'h20 || a == 'h28;
  endfunction

  // Expected contents after the full write sweep (ascending address order).
  function automatic logic [23:0] exp_after(input int a);
    if (a >= 'h60) return pat('h70 + (a % 16));
    if (a >= 'h50 && a < 'h60) return cval(a % 16);
    if (is_named(a)) return pat(a);
    return 24'h0;
  endfunction

  task automatic wr(input int a, input logic [23:0] d);
    @(negedge clk);
    reg_addr = 7'(a); reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic xfer(input bit ram, input bit w, input int wt, input logic [23:0] mar);
    int n;
    wr('h13, mar);
    rom_wait = ram ? 3'(7 - wt) : 3'(wt);
    ram_wait = ram ? 3'(wt) : 3'(7 - wt);
    @(negedge clk);
    reg_addr = ram ? 7'h2F : 7'h2E; reg_wr = w; reg_rd = ~w;
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0;
    chk("R6 bus_ram", 32'(bus_ram), 32'(ram));
    chk("R6 bus_wr", 32'(bus_wr), 32'(w));
    chk("R6 bus_rd", 32'(bus_rd), 32'(!w));
    chk("R6 bus_addr", 32'(bus_addr), 32'(mar));
    n = 0;
    while (bus_busy && n < 20) begin
      if (bus_rd && bus_wr) chk("R7 exclusive", 32'(1), 32'(0));
      n++;
      @(negedge clk);
    end
    chk("R7 busy length", 32'(n), 32'(1 + wt));
    chk("R7 idle flags", 32'({bus_rd, bus_wr}), 32'(0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 / R4 / R8: reset contents over all addresses
    chk("R1 busy after reset", 32'({bus_busy, bus_rd, bus_wr}), 32'(0));
    for (int a = 0; a < 128; a++) begin
      reg_addr = 7'(a); #1;
      if (a >= 'h50 && a < 'h60) chk("R4 const at reset", 32'(reg_rdata), 32'(cval(a % 16)));
      else chk("R1 reset zero", 32'(reg_rdata), 32'(0));
    end
    // Write every address with a distinct pattern.
    for (int a = 0; a < 128; a++) wr(a, pat(a));
    repeat (12) @(negedge clk);
    // R2 R3 R4 R5 R8: full read-back sweep
    for (int a = 0; a < 128; a++) begin
      @(negedge clk);
      reg_addr = 7'(a); #1;
      if (a == 1 || a == 2) chk("R2 mul half", 32'(reg_rdata), 32'(exp_after(a)));
      else if (is_named(a)) chk("R3 named reg", 32'(reg_rdata), 32'(exp_after(a)));
      else if (a >= 'h50 && a < 'h60) chk("R4 const ignores write", 32'(reg_rdata), 32'(exp_after(a)));
      else if (a >= 'h60) chk("R5 gpr alias", 32'(reg_rdata), 32'(exp_after(a)));
      else chk("R8 zero read", 32'(reg_rdata), 32'(0));
    end
    // R2: explicit half isolation
    wr(1, 24'hABCDEF);
    @(negedge clk); reg_addr = 7'h02; #1;
    chk("R2 low half kept", 32'(reg_rdata), 32'(pat(2)));
    wr(2, 24'h123456);
    @(negedge clk); reg_addr = 7'h01; #1;
    chk("R2 high half kept", 32'(reg_rdata), 32'(24'hABCDEF));
    // R5: write low alias, read high alias
    wr('h65, 24'h0F0F0F);
    @(negedge clk); reg_addr = 7'h75; #1;
    chk("R5 alias write", 32'(reg_rdata), 32'(24'h0F0F0F));
    // R6 R7: sweep target, direction and wait value
    for (int r = 0; r < 2; r++)
      for (int w = 0; w < 2; w++)
        for (int wt = 0; wt < 8; wt++)
          xfer(r[0], w[0], wt, {4'(wt), 4'(r), 4'(w), 12'hA5C} ^ 24'h5A0000);
    // R9: retrigger while busy
    wr('h13, 24'h111111);
    rom_wait = 3'd7; ram_wait = 3'd0;
    @(negedge clk); reg_addr = 7'h2E; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0;
    @(negedge clk);
    reg_addr = 7'h13; reg_wdata = 24'h222222; reg_wr = 1'b1;
    @(negedge clk);
    reg_addr = 7'h2F; reg_wdata = 24'h0; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    chk("R9 retrigger busy", 32'(bus_busy), 32'(1));
    chk("R9 retrigger dir", 32'({bus_ram, bus_wr}), 32'(2'b11));
    chk("R9 retrigger addr", 32'(bus_addr), 32'(24'h222222));
    @(negedge clk);
    chk("R9 retrigger length", 32'(bus_busy), 32'(0));
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule